// File: doc/BRIEF.md
# Single-Stream Peripheral-to-Memory DMA Engine

This block is one DMA stream that copies 16-bit items from a fixed peripheral address into a run of memory locations. The memory address rises by two bytes per item. Software loads an item count, a peripheral address, a memory start address and a source number while the stream is off, and then sets the enable bit. After that, every request the stream services on the chosen source line moves exactly one item. Each item is one bus read followed by one bus write. The engine returns a one-cycle acknowledge pulse to that source once the read has been accepted.

The stream raises a half-way flag and a completion flag. It turns itself off when its count reaches zero. A request line that is already high when the stream is enabled is served at once, because the stream has no memory of edges and only looks at the line level. Software cannot start a new run until it has cleared the completion flag.

The bus side is a valid/ready master. The engine holds `bus_valid` high and keeps `bus_addr`, `bus_write` and `bus_wdata` steady until the slave raises `bus_ready`. The slave can therefore stall either phase for any number of cycles. A read's data is taken from `bus_rdata` in the cycle where valid and ready are both high.

Top module: `pdma_stream`

## Requirements
- R1: After reset, `en_o`, `half_flag_o`, `done_flag_o`, `count_o`, `bus_valid` and `ack_o` are all zero.
- R2: Control register address 0 holds the enable in bit 0 and the source number in bits [2:1]. Only the request line whose index equals the source number is serviced. Requests on other lines cause no bus activity and no acknowledge, and they stay pending.
- R3: Each item is a read of the programmed peripheral address followed by a write of the data just read. Item i (counting from 0) is written to memory start address + 2*i. The peripheral address never changes.
- R4: Register address 1 loads the count. The count drops by one in the cycle after each completed memory write. When it reaches zero, `en_o` clears and `done_flag_o` sets on the same edge. The bus stays idle while `en_o` is low.
- R5: `half_flag_o` sets on the item after which the remaining count equals floor(programmed count / 2). For a count of 1 this is the last item.
- R6: A control write that sets bit 0 is ignored entirely while `done_flag_o` is set or the count is zero. Register address 4 clears `half_flag_o` when bit 0 is written as 1 and clears `done_flag_o` when bit 1 is written as 1.
- R7: If the selected line is already high when enable is written, the read request (`bus_valid` high, `bus_write` low) appears in the second cycle after the write cycle.
- R8: One request produces one item. `ack_o` is at most one-hot, pulses for a single cycle to the selected source, and is asserted in the cycle right after the read handshake.
- R9: While `en_o` is high, writes to the count (1), peripheral address (2), memory address (3) and control (0) registers are ignored.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 count, 2 peripheral address, 3 memory address, 4 flag clear |
| reg_wdata | input | ADDR_W | Register write data |
| req_i | input | NUM_SRC | Per-source request levels |
| ack_o | output | NUM_SRC | Per-source acknowledge pulses |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Slave accepts the access |
| bus_rdata | input | DATA_W | Read data, valid while `bus_valid & bus_ready & !bus_write` |
| en_o | output | 1 | Stream enable state |
| count_o | output | CNT_W | Remaining item count |
| half_flag_o | output | 1 | Half-way flag |
| done_flag_o | output | 1 | Completion flag |

## Verification
Every result has a fixed latency.
- A pending request causes `bus_valid` in the second cycle after the enable write.
- An acknowledge follows the read handshake by one cycle.
- Count, memory address, the half-way flag, the completion flag and the enable all change on the edge that ends the memory write.

The bench drives inputs and samples outputs on the falling edge, so every sample lands one full register stage after its cause. The bench checks the flag and count state in every cycle of every run against formulas computed from the number of writes seen so far. It checks the address and data of each bus access as the access completes. These checks are repeated under always-ready and randomly stalled bus slaves.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mv_state_t;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_COUNT = 3'd1;
  localparam logic [2:0] RA_PADDR = 3'd2;
  localparam logic [2:0] RA_MADDR = 3'd3;
  localparam logic [2:0] RA_FCLR  = 3'd4;

  localparam int ITEM_BYTES = 2;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              item_done,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              half_o,
  output logic              done_o
);
  logic              en_q, half_q, done_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] paddr_q, maddr_q;
  logic [CNT_W-1:0]  cnt_q, prog_q, cnt_dec, half_mark;
  logic              start_blocked;

  assign cnt_dec       = cnt_q - 1'b1;
  assign half_mark     = prog_q >> 1;
  assign start_blocked = done_q || (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      half_q  <= 1'b0;
      done_q  <= 1'b0;
      sel_q   <= '0;
      paddr_q <= '0;
      maddr_q <= '0;
      cnt_q   <= '0;
      prog_q  <= '0;
    end else begin
      // flag clearing is open at all times; a set on the same edge wins
      if (wr_en && wr_addr == RA_FCLR) begin
        if (wr_data[0]) half_q <= 1'b0;
        if (wr_data[1]) done_q <= 1'b0;
      end
      if (item_done) begin
        cnt_q   <= cnt_dec;
        maddr_q <= maddr_q + ADDR_W'(ITEM_BYTES);
        if (cnt_dec == half_mark) half_q <= 1'b1;
        if (cnt_dec == '0) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (wr_en && !en_q) begin
        case (wr_addr)
          RA_CTRL: begin
            if (!(wr_data[0] && start_blocked)) begin
              sel_q <= wr_data[SEL_W:1];
              en_q  <= wr_data[0];
            end
          end
          RA_COUNT: begin
            cnt_q  <= wr_data[CNT_W-1:0];
            prog_q <= wr_data[CNT_W-1:0];
          end
          RA_PADDR: paddr_q <= wr_data;
          RA_MADDR: maddr_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign en_o    = en_q;
  assign sel_o   = sel_q;
  assign paddr_o = paddr_q;
  assign maddr_o = maddr_q;
  assign cnt_o   = cnt_q;
  assign half_o  = half_q;
  assign done_o  = done_q;
endmodule

// File: rtl/pdma_req_route.sv
module pdma_req_route #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [SEL_W-1:0]   sel,
  input  logic               rd_done,
  output logic               req_hit,
  output logic [NUM_SRC-1:0] ack_o
);
  always_comb begin
    req_hit = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) req_hit = req_i[i];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_o[g] <= 1'b0;
      else        ack_o[g] <= rd_done && (sel == SEL_W'(g));
    end
  end
endmodule

// File: rtl/pdma_mover.sv
module pdma_mover
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req_hit,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [ADDR_W-1:0] maddr,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              rd_done,
  output logic              item_done
);
  mv_state_t         state_q;
  logic [DATA_W-1:0] data_q;

  assign rd_done   = (state_q == MV_READ)  && bus_ready;
  assign item_done = (state_q == MV_WRITE) && bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      data_q  <= '0;
    end else begin
      case (state_q)
        MV_IDLE:  if (en && req_hit) state_q <= MV_READ;
        MV_READ:  if (bus_ready) begin
                    data_q  <= bus_rdata;
                    state_q <= MV_WRITE;
                  end
        MV_WRITE: if (bus_ready) state_q <= MV_IDLE;
        default:  state_q <= MV_IDLE;
      endcase
    end
  end

  assign bus_valid = (state_q != MV_IDLE);
  assign bus_write = (state_q == MV_WRITE);
  assign bus_addr  = bus_write ? maddr : paddr;
  assign bus_wdata = data_q;
endmodule

// File: rtl/pdma_stream.sv
module pdma_stream #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [ADDR_W-1:0]  reg_wdata,
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] ack_o,
  output logic               bus_valid,
  output logic               bus_write,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ready,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               en_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               half_flag_o,
  output logic               done_flag_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] paddr, maddr;
  logic              req_hit, rd_done, item_done;

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .item_done(item_done),
    .en_o(en_o), .sel_o(sel), .paddr_o(paddr), .maddr_o(maddr),
    .cnt_o(count_o), .half_o(half_flag_o), .done_o(done_flag_o)
  );

  pdma_req_route #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) route_i (
    .clk(clk), .rst_n(rst_n),
    .req_i(req_i), .sel(sel), .rd_done(rd_done),
    .req_hit(req_hit), .ack_o(ack_o)
  );

  pdma_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mover_i (
    .clk(clk), .rst_n(rst_n),
    .en(en_o), .req_hit(req_hit), .paddr(paddr), .maddr(maddr),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_done(rd_done), .item_done(item_done)
  );
endmodule

// File: rtl/pdma_stream_chk.sv
module pdma_stream_chk #(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] ack_o,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_ready,
  input logic               en_o,
  input logic [CNT_W-1:0]   count_o,
  input logic               done_flag_o
);
  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_write) && $stable(bus_wdata)));

  p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));

  p_ack_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != '0) |-> $past(bus_valid && bus_ready && !bus_write));

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != '0) |=> (ack_o == '0));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_ready) |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> !bus_valid);

  p_done_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag_o) |-> !en_o);

  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o) |-> !$past(done_flag_o));
endmodule

bind pdma_stream pdma_stream_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ack_o(ack_o),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .en_o(en_o), .count_o(count_o), .done_flag_o(done_flag_o)
);

// File: tb/pdma_stream_tb_top.sv
`timescale 1ns/1ps
module pdma_stream_tb_top;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [NS-1:0] req_i;
  logic [NS-1:0] ack_o;
  logic          bus_valid, bus_write, bus_ready;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          en_o, half_flag_o, done_flag_o;
  logic [CW-1:0] count_o;

  always #10 clk = ~clk;

  pdma_stream #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_i(req_i), .ack_o(ack_o),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .en_o(en_o), .count_o(count_o), .half_flag_o(half_flag_o),
    .done_flag_o(done_flag_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // stimulus-side controls
  logic          mon_clr = 1'b0;
  logic [NS-1:0] raise_v = '0;
  logic          rdy_mode = 1'b0;
  logic [6:0]    lfsr = 7'h5A;
  logic [AW-1:0] exp_paddr = '0, exp_mbase = '0;
  int            run_n = 0;
  logic          run_on = 1'b0;

  // monitor state
  int wr_cnt = 0, rd_cnt = 0, item_bad = 0, rd_bad = 0, flag_err = 0;
  int ack_cnt [NS];
  int pend [NS];

  always_comb
    for (int s = 0; s < NS; s++) req_i[s] = (pend[s] > 0);

  assign bus_ready = rdy_mode ? lfsr[0] : 1'b1;
  assign bus_rdata = 16'hC000 ^ 16'(rd_cnt);

  always @(negedge clk) lfsr <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};

  initial for (int s = 0; s < NS; s++) begin ack_cnt[s] = 0; pend[s] = 0; end

  always @(posedge clk) begin
    if (mon_clr) begin
      wr_cnt <= 0; rd_cnt <= 0; item_bad <= 0; rd_bad <= 0;
      for (int s = 0; s < NS; s++) begin ack_cnt[s] <= 0; pend[s] <= 0; end
    end else begin
      if (bus_valid && bus_ready && !bus_write) begin
        rd_cnt <= rd_cnt + 1;
        if (bus_addr != exp_paddr) rd_bad <= rd_bad + 1;
      end
      if (bus_valid && bus_ready && bus_write) begin
        wr_cnt <= wr_cnt + 1;
        if (bus_addr != exp_mbase + 16'(2 * wr_cnt) ||
            bus_wdata != (16'hC000 ^ 16'(wr_cnt)))
          item_bad <= item_bad + 1;
      end
      for (int s = 0; s < NS; s++) begin
        ack_cnt[s] <= ack_cnt[s] + int'(ack_o[s]);
        pend[s]    <= pend[s] + int'(raise_v[s]) - int'(ack_o[s]);
      end
    end
  end

  // per-cycle flag model (R5, R4)
  always @(negedge clk) begin
    if (run_on) begin
      if (half_flag_o != ((run_n - wr_cnt) <= run_n / 2)) flag_err <= flag_err + 1;
      if (done_flag_o != (wr_cnt == run_n))               flag_err <= flag_err + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic raise(input int s);
    @(negedge clk); raise_v[s] = 1'b1;
    @(negedge clk); raise_v = '0;
  endtask

  task automatic clear_mon();
    run_on = 1'b0;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0; flag_err = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_flag_o && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_ack(input int s, input int k);
    int t = 0;
    while (ack_cnt[s] < k && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(en_o == 0 && half_flag_o == 0 && done_flag_o == 0, "R1 flags", {en_o, half_flag_o, done_flag_o}, 0);
    chk(count_o == 0 && bus_valid == 0 && ack_o == 0, "R1 count/bus", count_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: pending request is served right after enable
    clear_mon();
    rdy_mode = 1'b0;
    wr_reg(3'd4, 16'h3);
    wr_reg(3'd1, 16'd1);
    wr_reg(3'd2, 16'h4242);
    wr_reg(3'd3, 16'h1110);
    exp_paddr = 16'h4242; exp_mbase = 16'h1110;
    raise(2);
    repeat (3) @(negedge clk);
    chk(bus_valid == 0, "R7 quiet while off", bus_valid, 0);
    wr_reg(3'd0, 16'h5);
    chk(bus_valid == 0, "R7 first cycle after enable", bus_valid, 0);
    @(negedge clk);
    chk(bus_valid && !bus_write && bus_addr == 16'h4242, "R7 read issued", bus_addr, 16'h4242);
    wait_done(); @(negedge clk);
    chk(wr_cnt == 1 && item_bad == 0, "R7 item written", item_bad, 0);

    // R9 and R6
    clear_mon();
    wr_reg(3'd4, 16'h3);
    wr_reg(3'd1, 16'd3);
    wr_reg(3'd2, 16'h5550);
    wr_reg(3'd3, 16'h3000);
    exp_paddr = 16'h5550; exp_mbase = 16'h3000;
    wr_reg(3'd0, 16'h3);
    wr_reg(3'd1, 16'd9);
    wr_reg(3'd3, 16'h7000);
    wr_reg(3'd2, 16'h6660);
    wr_reg(3'd0, 16'h7);
    chk(count_o == 3, "R9 count write ignored", count_o, 3);
    raise(3);
    repeat (4) @(negedge clk);
    chk(bus_valid == 0 && ack_cnt[3] == 0, "R9 select write ignored", ack_cnt[3], 0);
    for (int k = 0; k < 3; k++) raise(1);
    wait_done(); @(negedge clk);
    chk(wr_cnt == 3, "R9 items", wr_cnt, 3);
    chk(item_bad == 0 && rd_bad == 0, "R9 addresses unchanged", item_bad + rd_bad, 0);
    wr_reg(3'd1, 16'd2);
    wr_reg(3'd0, 16'h3);
    repeat (2) @(negedge clk);
    chk(en_o == 0, "R6 enable refused while done set", en_o, 0);
    chk(count_o == 2, "R6 count loads while off", count_o, 2);
    wr_reg(3'd4, 16'h2);
    chk(done_flag_o == 0 && half_flag_o == 1, "R6 selective clear", {done_flag_o, half_flag_o}, 1);
    wr_reg(3'd0, 16'h3);
    chk(en_o == 1, "R6 enable after clear", en_o, 1);
    for (int k = 0; k < 2; k++) raise(1);
    wait_done(); @(negedge clk);
    chk(en_o == 0 && count_o == 0, "R4 stopped at zero", count_o, 0);

    // sweep: count x source x bus mode
    for (int mode = 0; mode < 2; mode++) begin
      for (int n = 1; n <= 7; n++) begin
        for (int sel = 0; sel < NS; sel++) begin
          clear_mon();
          rdy_mode = (mode == 1);
          wr_reg(3'd4, 16'h3);
          wr_reg(3'd1, 16'(n));
          exp_paddr = 16'h4000 + 16'(sel * 16 + n);
          exp_mbase = 16'h2000 + 16'(n * 64);
          wr_reg(3'd2, exp_paddr);
          wr_reg(3'd3, exp_mbase);
          run_n = n; run_on = 1'b1;
          for (int s = 0; s < NS; s++) if (s != sel) raise(s);
          if (mode == 0) for (int k = 0; k < n; k++) raise(sel);
          wr_reg(3'd0, 16'((sel << 1) | 1));
          if (mode == 1)
            for (int k = 0; k < n; k++) begin raise(sel); wait_ack(sel, k + 1); end
          wait_done(); @(negedge clk);
          chk(en_o == 0 && done_flag_o == 1, "R4 end state", {en_o, done_flag_o}, 1);
          chk(count_o == 0, "R4 count zero", count_o, 0);
          chk(wr_cnt == n, "R8 one item per request", wr_cnt, n);
          chk(item_bad == 0, "R3 memory address/data", item_bad, 0);
          chk(rd_bad == 0, "R3 fixed peripheral address", rd_bad, 0);
          chk(flag_err == 0, "R5 half/done timing", flag_err, 0);
          chk(ack_cnt[sel] == n, "R8 acks to selected", ack_cnt[sel], n);
          for (int s = 0; s < NS; s++) if (s != sel) begin
            chk(ack_cnt[s] == 0 && pend[s] == 1, "R2 unselected ignored", ack_cnt[s], 0);
          end
        end
      end
    end

    run_on = 1'b0;
    summary();
    $finish;
  end
endmodule